// File: doc/BRIEF.md
# Light and Proximity Sensor I2C Register Target

This block is the I2C target front end of an ambient-light and proximity sensor. It samples the bus clock and data lines with the system clock and finds start, stop and clock edges. It answers to a 7-bit address whose six upper bits are fixed and whose lowest bit comes from a select pin. It drives SDA only as an open-drain pull-down.

A host sets a register pointer by writing it after the address byte. Any further bytes in the same transfer go to the register at that pointer. To read, the host writes the pointer, sends a repeated start, then sends the address again with the read bit set. The target then shifts out the selected register, MSB first.

The sensor core supplies a 12-bit light result and an 8-bit proximity result. Each comes with a one-cycle valid strobe. There is no ready signal: the block takes a strobe in any cycle, so the core never sees back-pressure. Two host-writable test registers drive a single test-mode flag.

Top module: `lpx_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal binary 100010 followed by `addr_sel`, by pulling SDA low during the ninth clock. Bit 0 of that byte is read/write, with 1 meaning read.
- R2: When the address does not match, the target leaves SDA released for the rest of the transfer, including all later bytes, until the next start or stop.
- R3: A start or stop is recognised at any point, including in the middle of a byte. A start always begins a fresh address byte.
- R4: In a write transfer, the byte after the address is loaded into the register pointer. Each later byte is written to the register at that pointer. The target acknowledges every one of these bytes.
- R5: A read is a pointer write, then a repeated start, then the address with the read bit set. The target shifts out the register at the pointer, MSB first.
- R6: Register 0x08 holds the proximity result captured on `prox_valid`. It resets to 0x00.
- R7: Register 0x09 returns bits 7:0 of the light result. Register 0x0A returns bits 11:8 of the light result in its bits 3:0, and its bits 7:4 read as 0.
- R8: Registers 0x0E and 0x0F can be written and read back, and both reset to 0x00. `test_mode` is 1 exactly while either register holds a nonzero value.
- R9: On `als_valid`, all 12 light bits are captured in the same cycle. Registers 0x09 and 0x0A therefore always come from the same conversion.
- R10: If the host answers a read byte with NACK, the target releases SDA and stays silent until a start or stop. If the host answers with ACK, the same register is sent again.
- R11: A read from any address not listed above returns 0x00. A write to 0x08, 0x09, 0x0A or an unlisted address is acknowledged but changes nothing.
- R12: SCL and SDA each pass through a two-flop synchronizer. The target changes its SDA drive only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Lowest bit of the target address |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| als_valid | input | 1 | One-cycle strobe: new light result on `als_data` |
| als_data | input | 12 | Light conversion result |
| prox_valid | input | 1 | One-cycle strobe: new proximity result on `prox_data` |
| prox_data | input | 8 | Proximity conversion result |
| test_mode | output | 1 | High while either test register is nonzero |

## Verification
The assertions assume the host keeps SCL low for several system clocks after each falling edge, so that a drive change from the target lands in the low phase. They also assume a repeated start is only issued while the target has released SDA. The bench holds every SCL phase for eight clocks and changes its data only in the middle of the low phase. It issues starts and stops only at bit boundaries, or where the target is not driving. The bench also checks, at the pins, that the drive never changes while the raw SCL is high.

// File: rtl/lpx_i2c_pkg.sv
package lpx_i2c_pkg;
  localparam int REG_W = 8;
  localparam logic [7:0] OFS_PROX   = 8'h08;
  localparam logic [7:0] OFS_ALS_LO = 8'h09;
  localparam logic [7:0] OFS_ALS_HI = 8'h0A;
  localparam logic [7:0] OFS_TEST0  = 8'h0E;
  localparam int N_TEST = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_REG, ST_WDATA, ST_RDATA, ST_MACK, ST_WAIT
  } fsm_st_t;
endpackage

// File: rtl/lpx_bus_sync.sv
module lpx_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int PW = STAGES + 1;
  logic [PW-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[PW-2:0], scl_i};
      sda_p <= {sda_p[PW-2:0], sda_i};
    end
  end

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];
  assign scl_d = scl_p[STAGES];
  assign sda_d = sda_p[STAGES];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/lpx_i2c_fsm.sv
module lpx_i2c_fsm
  import lpx_i2c_pkg::*;
#(
  parameter logic [5:0] PREFIX = 6'b100010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             addr_sel,
  input  logic [REG_W-1:0] rd_data,
  output logic             sda_oe,
  output logic [REG_W-1:0] ptr,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_data
);
  localparam int CW = $clog2(REG_W + 1);

  fsm_st_t st, ack_nx;
  logic [CW-1:0] cnt;
  logic [REG_W-1:0] sh;
  logic m_ack;
  logic byte_in, addr_hit;

  assign byte_in  = (cnt == CW'(REG_W));
  assign addr_hit = (sh[REG_W-1:1] == {PREFIX, addr_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ack_nx  <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (bus_start) begin
        st     <= ST_ADDR;
        sda_oe <= 1'b0;
        cnt    <= '0;
      end else if (scl_rise) begin
        case (st)
          ST_ADDR, ST_REG, ST_WDATA:
            if (!byte_in) begin
              sh  <= {sh[REG_W-2:0], sda_s};
              cnt <= cnt + CW'(1);
            end
          ST_RDATA: cnt <= cnt + CW'(1);
          ST_MACK:  m_ack <= ~sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          ST_ADDR:
            if (byte_in) begin
              cnt <= '0;
              if (addr_hit) begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                ack_nx <= sh[0] ? ST_RDATA : ST_REG;
              end else begin
                st <= ST_WAIT;
              end
            end
          ST_REG:
            if (byte_in) begin
              ptr    <= sh;
              cnt    <= '0;
              sda_oe <= 1'b1;
              st     <= ST_ACK;
              ack_nx <= ST_WDATA;
            end
          ST_WDATA:
            if (byte_in) begin
              wr_en   <= 1'b1;
              wr_data <= sh;
              cnt     <= '0;
              sda_oe  <= 1'b1;
              st      <= ST_ACK;
              ack_nx  <= ST_WDATA;
            end
          ST_ACK: begin
            cnt <= '0;
            st  <= ack_nx;
            if (ack_nx == ST_RDATA) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[REG_W-1];
            end else begin
              sda_oe <= 1'b0;
            end
          end
          ST_RDATA:
            if (byte_in) begin
              sda_oe <= 1'b0;
              st     <= ST_MACK;
            end else begin
              sh     <= {sh[REG_W-2:0], 1'b0};
              sda_oe <= ~sh[REG_W-2];
            end
          ST_MACK:
            if (m_ack) begin
              cnt    <= '0;
              sh     <= rd_data;
              sda_oe <= ~rd_data[REG_W-1];
              st     <= ST_RDATA;
            end else begin
              st <= ST_WAIT;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lpx_regbank.sv
module lpx_regbank
  import lpx_i2c_pkg::*;
#(
  parameter int ALS_W  = 12,
  parameter int PROX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              als_valid,
  input  logic [ALS_W-1:0]  als_data,
  input  logic              prox_valid,
  input  logic [PROX_W-1:0] prox_data,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              test_mode
);
  logic [ALS_W-1:0]  als_q;
  logic [PROX_W-1:0] prox_q;
  logic [N_TEST-1:0][REG_W-1:0] tst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      als_q  <= '0;
      prox_q <= '0;
      tst    <= '0;
    end else begin
      if (als_valid)  als_q  <= als_data;
      if (prox_valid) prox_q <= prox_data;
      for (int i = 0; i < N_TEST; i++)
        if (wr_en && addr == OFS_TEST0 + REG_W'(i)) tst[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      OFS_PROX:   rd_data = REG_W'(prox_q);
      OFS_ALS_LO: rd_data = als_q[REG_W-1:0];
      OFS_ALS_HI: rd_data = REG_W'(als_q[ALS_W-1:REG_W]);
      default: ;
    endcase
    for (int i = 0; i < N_TEST; i++)
      if (addr == OFS_TEST0 + REG_W'(i)) rd_data = tst[i];
  end

  always_comb begin
    test_mode = 1'b0;
    for (int i = 0; i < N_TEST; i++) test_mode = test_mode | (|tst[i]);
  end
endmodule

// File: rtl/lpx_i2c_target.sv
module lpx_i2c_target
  import lpx_i2c_pkg::*;
#(
  parameter logic [5:0] PREFIX = 6'b100010,
  parameter int ALS_W  = 12,
  parameter int PROX_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  input  logic              als_valid,
  input  logic [ALS_W-1:0]  als_data,
  input  logic              prox_valid,
  input  logic [PROX_W-1:0] prox_data,
  output logic              test_mode
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_en;
  logic [REG_W-1:0] ptr, wr_data, rd_data;

  lpx_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  lpx_i2c_fsm #(.PREFIX(PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .addr_sel(addr_sel), .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  lpx_regbank #(.ALS_W(ALS_W), .PROX_W(PROX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .als_valid(als_valid), .als_data(als_data),
    .prox_valid(prox_valid), .prox_data(prox_data), .wr_en(wr_en),
    .addr(ptr), .wr_data(wr_data), .rd_data(rd_data), .test_mode(test_mode)
  );
endmodule

// File: rtl/lpx_i2c_target_chk.sv
module lpx_i2c_target_chk
  import lpx_i2c_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_s,
  input logic             bus_start,
  input logic             bus_stop,
  input logic             wr_en,
  input logic [REG_W-1:0] ptr,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             als_valid,
  input logic [7:0]       als_lo,
  input logic             prox_valid,
  input logic             test_mode
);
  a_r12_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(bus_start) || $past(bus_stop)));

  a_r8_test_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == OFS_TEST0 && wr_data != '0) |=> test_mode);

  a_r7_hi_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == OFS_ALS_HI) |-> (rd_data[7:4] == 4'h0));

  a_r9_light_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (als_valid && ptr == OFS_ALS_LO) |=> (ptr != OFS_ALS_LO || rd_data == $past(als_lo)));

  a_r11_prox_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == OFS_PROX && !prox_valid) |=> (ptr != OFS_PROX || rd_data == $past(rd_data)));
endmodule

bind lpx_i2c_target lpx_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .bus_start(bus_start), .bus_stop(bus_stop), .wr_en(wr_en), .ptr(ptr),
  .wr_data(wr_data), .rd_data(rd_data), .als_valid(als_valid),
  .als_lo(als_data[7:0]), .prox_valid(prox_valid), .test_mode(test_mode)
);

// File: tb/lpx_i2c_target_tb.sv
module lpx_i2c_target_tb;
  logic clk = 0, rst_n = 0;
  logic scl_i = 1, sda_m = 1, addr_sel = 0;
  logic als_valid = 0, prox_valid = 0;
  logic [11:0] als_data = '0;
  logic [7:0]  prox_data = '0;
  logic sda_oe, test_mode, sda_line;
  int checks = 0, errors = 0, viol = 0;
  logic oe_q = 0;
  logic [11:0] als_m = '0;
  logic [7:0] prox_m = '0, t0_m = '0, t1_m = '0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  lpx_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .als_valid(als_valid),
    .als_data(als_data), .prox_valid(prox_valid), .prox_data(prox_data),
    .test_mode(test_mode)
  );

  // R12: drive must not move while the raw clock line is high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_q && scl_i) viol++;
    oe_q = sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; half(); scl_i = 1; half(); sda_m = 0; half(); scl_i = 0; half();
  endtask

  task automatic bus_stop();
    sda_m = 0; half(); scl_i = 1; half(); sda_m = 1; half();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; half(); scl_i = 1; half(); scl_i = 0; half();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1; half(); scl_i = 1;
    repeat (4) @(negedge clk);
    b = sda_line;
    repeat (4) @(negedge clk);
    scl_i = 0; half();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic host_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~host_ack);
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {6'b100010, addr_sel, rw};
  endfunction

  function automatic logic [7:0] exp_reg(input logic [7:0] a);
    case (a)
      8'h08: return prox_m;
      8'h09: return als_m[7:0];
      8'h0A: return {4'h0, als_m[11:8]};
      8'h0E: return t0_m;
      8'h0F: return t1_m;
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input string tag);
    logic ack;
    bus_start();
    wbyte(dev(0), ack); chk({tag, " addr ack"}, ack, 1);
    wbyte(a, ack);      chk({tag, " ptr ack"}, ack, 1);
    wbyte(d, ack);      chk({tag, " data ack"}, ack, 1);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    logic ack;
    bus_start();
    wbyte(dev(0), ack); chk("R5 write addr ack", ack, 1);
    wbyte(a, ack);      chk("R5 ptr ack", ack, 1);
    bus_start();
    wbyte(dev(1), ack); chk("R5 read addr ack", ack, 1);
    rbyte(v, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic ack, b;
    repeat (4) @(negedge clk);
    chk("R12 reset sda_oe", sda_oe, 0);
    chk("R8 reset test_mode", test_mode, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    rd_reg(8'h08, v); chk("R6 prox reset value", v, 0);
    rd_reg(8'h0F, v); chk("R8 test reg reset value", v, 0);

    // R1 R2: every 7-bit address with both select values
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      for (int a = 0; a < 128; a++) begin
        bus_start();
        wbyte({a[6:0], 1'b0}, ack);
        chk($sformatf("R1 R2 address 0x%0h sel %0d", a, s), ack,
            (a[6:0] == {6'b100010, s[0]}) ? 1 : 0);
        bus_stop();
      end
    end
    addr_sel = 1;

    // R2: later bytes after a mismatch stay unacknowledged
    bus_start();
    wbyte(8'h10, ack); chk("R2 foreign address", ack, 0);
    wbyte({6'b100010, 1'b1, 1'b0}, ack); chk("R2 silent after mismatch", ack, 0);
    bus_stop();

    // R6 R7 R11 R5: full register sweep with known results
    @(negedge clk);
    prox_data = 8'hA5; prox_valid = 1; als_data = 12'hBCD; als_valid = 1;
    @(negedge clk);
    prox_valid = 0; als_valid = 0; prox_data = 8'h00; als_data = 12'h000;
    prox_m = 8'hA5; als_m = 12'hBCD;
    for (int a = 0; a < 20; a++) begin
      rd_reg(a[7:0], v);
      chk($sformatf("R6 R7 R11 read reg 0x%0h", a), v, exp_reg(a[7:0]));
    end

    // R4 R8: test register writes and flag
    wr_reg(8'h0E, 8'h5A, "R4"); t0_m = 8'h5A;
    rd_reg(8'h0E, v); chk("R8 test0 readback", v, 8'h5A);
    chk("R8 flag with test0 set", test_mode, 1);
    wr_reg(8'h0E, 8'h00, "R4"); t0_m = 0;
    chk("R8 flag cleared", test_mode, 0);
    wr_reg(8'h0F, 8'h01, "R4"); t1_m = 8'h01;
    chk("R8 flag with test1 set", test_mode, 1);
    rd_reg(8'h0F, v); chk("R8 test1 readback", v, 8'h01);
    wr_reg(8'h0F, 8'h00, "R4"); t1_m = 0;
    chk("R8 flag cleared again", test_mode, 0);

    // R4: two data bytes in one transfer land at the same pointer
    bus_start();
    wbyte(dev(0), ack); wbyte(8'h0E, ack);
    wbyte(8'h11, ack); chk("R4 first data ack", ack, 1);
    wbyte(8'h22, ack); chk("R4 second data ack", ack, 1);
    bus_stop(); t0_m = 8'h22;
    rd_reg(8'h0E, v); chk("R4 last byte kept", v, 8'h22);
    wr_reg(8'h0E, 8'h00, "R4"); t0_m = 0;

    // R11: writes to read-only and unmapped registers are ignored
    wr_reg(8'h08, 8'hFF, "R11");
    wr_reg(8'h0A, 8'hFF, "R11");
    wr_reg(8'h03, 8'h77, "R11");
    rd_reg(8'h08, v); chk("R11 prox unchanged", v, 8'hA5);
    rd_reg(8'h0A, v); chk("R11 light high unchanged", v, 8'h0B);
    rd_reg(8'h03, v); chk("R11 unmapped still zero", v, 0);
    chk("R11 flag untouched", test_mode, 0);

    // R9: a new conversion updates both halves
    @(negedge clk); als_data = 12'h3F1; als_valid = 1;
    @(negedge clk); als_valid = 0; als_data = 12'hFFF; als_m = 12'h3F1;
    rd_reg(8'h09, v); chk("R9 low byte", v, 8'hF1);
    rd_reg(8'h0A, v); chk("R9 high nibble", v, 8'h03);

    // R10: host ACK repeats the register, NACK silences the target
    bus_start();
    wbyte(dev(0), ack); wbyte(8'h08, ack);
    bus_start();
    wbyte(dev(1), ack);
    rbyte(v, 1'b1); chk("R10 first byte", v, 8'hA5);
    rbyte(v, 1'b0); chk("R10 repeated byte", v, 8'hA5);
    rbit(b); chk("R10 released after NACK", b, 1);
    rbit(b); chk("R10 still released", b, 1);
    bus_stop();

    // R3: start in the middle of a byte, then stop mid-transfer
    bus_start();
    wbit(1); wbit(0); wbit(0); wbit(0);
    rd_reg(8'h09, v); chk("R3 read after aborted byte", v, 8'hF1);
    bus_start();
    wbyte(dev(0), ack); wbit(0); wbit(0);
    bus_stop();
    rd_reg(8'h0A, v); chk("R3 read after early stop", v, 8'h03);

    chk("R12 drive changes while SCL high", viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule